// File: doc/BRIEF.md
# Reset Cause Collector with Stretched System Reset

This block gathers every reset request in the chip into one system reset line and keeps an 8-bit status byte that names the source of the most recent reset. The requesters are a power-on event, a supply-voltage monitor trip, an external reset pin, a clock-loss detector, a watchdog expiry, a software force, a comparator output and a flash access fault. The analog monitor, the comparator front end, the clock-loss circuit and the watchdog counter sit outside the block. Each one arrives here as a plain level or one-cycle input. The system reset is held for a fixed number of cycles after the last request goes away, so that the rest of the chip sees a clean, wide pulse.

The status byte has two meanings for the same bit. A write to certain bits arms a source or forces a reset. A read of those bits returns cause flags. The stored arming state is kept in separate internal flops and can never be read back. For this reason software must write the full byte it wants and must not read, modify and write the register. All pins are plain control and status signals. Nothing streams through the block, so there is no valid/ready handshake and no back-pressure. The register port is a single-cycle select/write strobe with combinational read data.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Bit 7 of the register always reads 0, and a write to it has no effect. The read layout is: bit 6 flash fault, bit 5 comparator, bit 4 software, bit 3 watchdog, bit 2 clock loss, bit 1 power-on/supply monitor, bit 0 pin.
- R2: While `pwr_on_rst` is high, `sys_rst` is high. Once it is released, the register reads 0x02. After power-on the comparator and clock-loss sources are disarmed and the supply monitor is armed.
- R3: A request that is sampled at a clock edge drives `sys_rst` high after that edge. `sys_rst` then stays high for exactly `STRETCH_CYCLES` (default 16) clock cycles, counted from the first edge at which no request is active.
- R4: At every clock edge with a request active, the cause flags are replaced by a single flag: the one for the highest-priority active source. The priority from highest to lowest is power-on/supply, pin, clock loss, watchdog, software, comparator, flash fault. All other flags read 0.
- R5: A register write with bit 4 set forces a reset, and bit 4 reads 1 afterwards. A write with bit 4 clear forces nothing.
- R6: A write sets the comparator arm from bit 5. When armed, `cmp_out` low requests a reset with flag bit 5. When disarmed, `cmp_out` low has no effect.
- R7: A write sets the clock-loss arm from bit 2. When armed, `clk_lost` requests a reset with flag bit 2. When disarmed, it has no effect.
- R8: A write sets the supply-monitor arm from bit 1. When armed, `supply_low` requests a reset with flag bit 1. A supply-monitor reset leaves all arms unchanged. When disarmed, `supply_low` has no effect.
- R9: `pin_rst`, `wdt_expire` and `flash_err` always request a reset, with flags bit 0, bit 3 and bit 6. A write to bits 6, 3 or 0 changes nothing.
- R10: A reset does not alter the arms, except on power-on. A read returns the cause flags, never the arms.
- R11: A write acts only when `reg_sel` and `reg_wr` are both high. `reg_rdata` shows the register while `reg_sel` is high and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_on_rst | input | 1 | Power-on event, active high; also resets the block's own state |
| supply_low | input | 1 | Supply-monitor trip, level |
| pin_rst | input | 1 | External reset pin, synchronised, active high |
| clk_lost | input | 1 | Clock-loss detector timeout |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| cmp_out | input | 1 | Comparator output; low requests a reset when armed |
| flash_err | input | 1 | Flash access fault pulse |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
The case that is hardest to reach from the ports is several requests arriving in the same cycle. This covers a software force combined with an armed comparator and a flash fault, where only the winning flag may survive. The stimulus table sets the needed arms first. It then raises several requesters, and a write with bit 4, together in a single cycle, removing the winner one step at a time to walk down the whole priority chain. Because the arms cannot be read, the bench checks them only through their effect. It fires a disarmed source and expects no reset. It fires a second clock-loss request after a supply-monitor reset and expects a reset, which shows that the arm survived.

// File: rtl/rst_cause_pkg.sv
`timescale 1ns/1ps
package rst_cause_pkg;
  localparam int NSRC  = 7;
  localparam int REG_W = 8;

  // flag bit positions; software decodes these
  localparam int B_PIN = 0;
  localparam int B_POR = 1;
  localparam int B_MCD = 2;
  localparam int B_WDT = 3;
  localparam int B_SW  = 4;
  localparam int B_CMP = 5;
  localparam int B_FLE = 6;

  // highest priority first
  localparam int PRIO [NSRC] = '{B_POR, B_PIN, B_MCD, B_WDT, B_SW, B_CMP, B_FLE};

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rst_cause_arb.sv
`timescale 1ns/1ps
module rst_cause_arb
  import rst_cause_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  src_vec_t req,
  output src_vec_t grant,
  output logic     any_req
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && req[PRIO[i]]) begin
        grant[PRIO[i]] = 1'b1;
        found          = 1'b1;
      end
    end
  end

  assign any_req = |req;

  // R4: at most one winner, and only among the active requesters
  p_grant_single_r4: assert property (@(posedge clk) disable iff (por) $onehot0(grant));
  p_grant_in_req_r4: assert property (@(posedge clk) disable iff (por) (grant & ~req) == '0);
  p_grant_any_r4:    assert property (@(posedge clk) disable iff (por) (|req) == (|grant));
endmodule

// File: rtl/rst_cause_stretch.sv
`timescale 1ns/1ps
module rst_cause_stretch #(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic clk,
  input  logic por,
  input  logic any_req,
  output logic rst_out
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (any_req)           cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign rst_out = (cnt_q != '0);

  // R3: a sampled request always yields reset; no reset appears from idle
  p_req_rst_r3:  assert property (@(posedge clk) disable iff (por) any_req |=> rst_out);
  p_no_spur_r3:  assert property (@(posedge clk) disable iff (por) (!any_req && !rst_out) |=> !rst_out);
endmodule

// File: rtl/rst_cause_regs.sv
`timescale 1ns/1ps
module rst_cause_regs
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             sel,
  input  logic             wr_hit,
  input  logic [2:0]       arm_wdata,   // {cmp, mcd, vdm}
  input  logic             take,
  input  src_vec_t         grant,
  output logic [REG_W-1:0] rdata,
  output logic             cmp_arm,
  output logic             mcd_arm,
  output logic             vdm_arm
);
  src_vec_t flags_q;

  always_ff @(posedge clk) begin
    if (por) begin
      cmp_arm <= 1'b0;
      mcd_arm <= 1'b0;
      vdm_arm <= 1'b1;
    end else if (wr_hit) begin
      cmp_arm <= arm_wdata[2];
      mcd_arm <= arm_wdata[1];
      vdm_arm <= arm_wdata[0];
    end
    if (take) flags_q <= grant;
  end

  assign rdata = sel ? {1'b0, flags_q} : '0;

  // R4: exactly one cause recorded after power-on
  p_flag_onehot_r4: assert property (@(posedge clk) disable iff (por) $onehot(flags_q));
  // R10: flags only move when a reset is taken
  p_flag_hold_r10:  assert property (@(posedge clk) disable iff (por) !take |=> $stable(flags_q));
  // R6: a write loads the arms from the data bits
  p_arm_load_r6:    assert property (@(posedge clk) disable iff (por)
                      wr_hit |=> {cmp_arm, mcd_arm, vdm_arm} == $past(arm_wdata));
  // R11: unselected arms keep their value
  p_arm_keep_r11:   assert property (@(posedge clk) disable iff (por)
                      !wr_hit |=> $stable({cmp_arm, mcd_arm, vdm_arm}));
endmodule

// File: rtl/rst_cause_ctrl.sv
`timescale 1ns/1ps
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic             clk,
  input  logic             pwr_on_rst,
  input  logic             supply_low,
  input  logic             pin_rst,
  input  logic             clk_lost,
  input  logic             wdt_expire,
  input  logic             cmp_out,
  input  logic             flash_err,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst
);
  logic     wr_hit;
  logic     cmp_arm, mcd_arm, vdm_arm;
  logic     any_req;
  src_vec_t req, grant;
  logic     unused_wbits;

  assign wr_hit       = reg_sel & reg_wr;
  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[3], reg_wdata[0]};

  always_comb begin
    req        = '0;
    req[B_POR] = pwr_on_rst | (supply_low & vdm_arm);
    req[B_PIN] = pin_rst;
    req[B_MCD] = clk_lost & mcd_arm;
    req[B_WDT] = wdt_expire;
    req[B_SW]  = wr_hit & reg_wdata[B_SW];
    req[B_CMP] = cmp_arm & ~cmp_out;
    req[B_FLE] = flash_err;
  end

  rst_cause_arb u_arb (
    .clk     (clk),
    .por     (pwr_on_rst),
    .req     (req),
    .grant   (grant),
    .any_req (any_req)
  );

  rst_cause_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk     (clk),
    .por     (pwr_on_rst),
    .any_req (any_req),
    .rst_out (sys_rst)
  );

  rst_cause_regs u_regs (
    .clk       (clk),
    .por       (pwr_on_rst),
    .sel       (reg_sel),
    .wr_hit    (wr_hit),
    .arm_wdata ({reg_wdata[B_CMP], reg_wdata[B_MCD], reg_wdata[B_POR]}),
    .take      (any_req),
    .grant     (grant),
    .rdata     (reg_rdata),
    .cmp_arm   (cmp_arm),
    .mcd_arm   (mcd_arm),
    .vdm_arm   (vdm_arm)
  );

  // R5: a software force always produces a reset
  p_sw_force_r5: assert property (@(posedge clk) disable iff (pwr_on_rst)
                   (wr_hit && reg_wdata[B_SW]) |=> sys_rst);
  // R1: the top bit never reads as 1
  p_top_bit_r1:  assert property (@(posedge clk) disable iff (pwr_on_rst) !reg_rdata[7]);
endmodule

// File: tb/sim_rst_cause_ctrl.sv
`timescale 1ns/1ps
module sim_rst_cause_ctrl;
  logic       clk = 1'b0;
  logic       pwr_on_rst = 1'b1;
  logic       supply_low = 1'b0, pin_rst = 1'b0, clk_lost = 1'b0;
  logic       wdt_expire = 1'b0, cmp_out = 1'b1, flash_err = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst;

  int checks = 0;
  int bad    = 0;

  always #2 clk = ~clk;

  rst_cause_ctrl u0 (
    .clk(clk), .pwr_on_rst(pwr_on_rst), .supply_low(supply_low), .pin_rst(pin_rst),
    .clk_lost(clk_lost), .wdt_expire(wdt_expire), .cmp_out(cmp_out), .flash_err(flash_err),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst(sys_rst)
  );

  // {arm byte, pulse mask, expect reset, expect read}
  // pulse mask: b0 pin, b1 supply, b2 clk_lost, b3 wdt, b4 sw write, b5 cmp low, b6 flash
  localparam int NV = 17;
  localparam logic [31:0] TAB [NV] = '{
    32'h02_01_01_01, 32'h02_08_01_08, 32'h02_40_01_40, 32'h02_10_01_10,
    32'h00_04_00_10, 32'h04_04_01_04, 32'h00_20_00_04, 32'h20_20_01_20,
    32'h00_02_00_20, 32'h02_02_01_02, 32'h02_59_01_01, 32'h26_7C_01_04,
    32'h26_78_01_08, 32'h26_70_01_10, 32'h26_60_01_20, 32'h26_03_01_02,
    32'h00_00_00_02
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // one-cycle pulse; returns at the negedge after the sampling edge
  task automatic fire(input logic [7:0] arm, input logic [7:0] p);
    @(negedge clk);
    pin_rst = p[0]; supply_low = p[1]; clk_lost = p[2]; wdt_expire = p[3];
    cmp_out = ~p[5]; flash_err = p[6];
    if (p[4]) begin reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = arm | 8'h10; end
    @(negedge clk);
    pin_rst = 1'b0; supply_low = 1'b0; clk_lost = 1'b0; wdt_expire = 1'b0;
    cmp_out = 1'b1; flash_err = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  // counts high samples after the current negedge until sys_rst drops
  task automatic count_hi(output int n);
    n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (!sys_rst) break;
      n++;
    end
  endtask

  task automatic settle();
    for (int k = 0; k < 64 && sys_rst; k++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int n;

    // R2: power-on
    repeat (4) @(negedge clk);
    chk("R2 rst during power-on", sys_rst, 1);
    pwr_on_rst = 1'b0;
    count_hi(n);
    chk("R3 stretch after power-on", n, 16);
    rd(v);
    chk("R2 flags after power-on", v, 8'h02);
    fire(8'h00, 8'h04);
    chk("R2 clock-loss disarmed at power-on", sys_rst, 0);
    fire(8'h00, 8'h20);
    chk("R2 comparator disarmed at power-on", sys_rst, 0);
    fire(8'h00, 8'h02);
    chk("R2 supply monitor armed at power-on", sys_rst, 1);
    settle();

    // R4 R5 R6 R7 R8 R9: table walk
    for (int i = 0; i < NV; i++) begin
      wr(TAB[i][31:24]);
      fire(TAB[i][31:24], TAB[i][23:16]);
      chk($sformatf("R4 vec%0d reset", i), sys_rst, TAB[i][8]);
      settle();
      rd(v);
      chk($sformatf("R4 vec%0d flags", i), v, TAB[i][7:0]);
    end

    // R3: held request, exact stretch
    @(negedge clk); pin_rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 rst while held", sys_rst, 1);
    pin_rst = 1'b0;
    count_hi(n);
    chk("R3 stretch length", n, 16);

    // R1 R9: write to read-only bits and bit 7 changes nothing
    wr(8'hC9);
    repeat (3) @(negedge clk);
    chk("R9 no reset from read-only bits", sys_rst, 0);
    rd(v);
    chk("R1 read-only write ignored", v, 8'h01);

    // R11: write without select is ignored; unselected read is 0
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h10;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R11 unselected sw write", sys_rst, 0);
    #1 chk("R11 unselected read", reg_rdata, 8'h00);

    // R8 R10: supply reset keeps the arms; read shows flags, not arms
    wr(8'h26);
    rd(v);
    chk("R10 read returns flags", v, 8'h01);
    fire(8'h26, 8'h02);
    settle();
    rd(v);
    chk("R8 supply flag", v, 8'h02);
    fire(8'h00, 8'h04);
    chk("R10 arm survives reset", sys_rst, 1);
    settle();
    rd(v);
    chk("R7 clock-loss flag again", v, 8'h04);

    // R5: write with bit 4 clear forces nothing
    wr(8'h26);
    repeat (2) @(negedge clk);
    chk("R5 no force without bit 4", sys_rst, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule